// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block gives an in-order five-stage pipeline precise exceptions. The fetch, decode and execute stages can each flag a fault on the instruction they hold. Each flag travels with the instruction's PC through a chain of stage records. Nothing acts on a flag until the instruction reaches the memory stage, which is the single commit point. The memory stage can add a data address fault of its own, and an asynchronous interrupt request is latched as pending and taken there as well.

When an instruction commits with an exception, the unit does five things in the same cycle. It kills the three younger stages and selects the handler PC for fetch. It blocks the memory access of the excepting instruction. On the closing edge it records the cause code and the excepting PC. In the following cycle it suppresses that instruction's writeback. The pipeline advances every cycle. The killed stages become empty slots, so a second exception can never commit in the cycle right after the first.

Top module: `exc_commit_unit`

## Requirements
- R1: A flag raised in fetch, decode or execute has no visible effect until its instruction occupies the memory stage, which is three edges after the instruction is fetched. The unit then raises `handler_sel` during that cycle.
- R2: If one instruction is flagged in several stages, the earliest stage wins. The order is fetch address fault, then illegal opcode, then overflow, then data address fault.
- R3: A pending interrupt is taken on the next valid instruction in the memory stage and overrides any fault that instruction carries. The excepting PC is that instruction's PC.
- R4: Cause codes are 1 for interrupt, 2 for fetch address fault, 3 for illegal opcode, 4 for overflow and 5 for data address fault. `cause_q` and `epc_q` load on the edge that ends a commit cycle and hold their value at every other edge.
- R5: In a commit cycle `kill_f`, `kill_d` and `kill_e` are high. The younger instructions become empty slots and never commit, even if they carry flags of their own.
- R6: `wb_suppress` is high in exactly the cycle after each commit cycle and low otherwise.
- R7: `m_mem_ok` is high for a valid, unflagged instruction in the memory stage. It is low when that instruction commits an exception and low when the memory stage is empty.
- R8: An interrupt request that arrives while no valid instruction reaches the memory stage stays pending. It does not commit until a valid instruction arrives there.
- R9: Fault inputs for a stage that holds no valid instruction have no effect.
- R10: After reset, `cause_q` and `epc_q` are zero and `handler_sel` and `wb_suppress` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_addr_fault | input | 1 | Fetch address fault on the fetched instruction |
| d_illegal | input | 1 | Decode found an illegal opcode |
| e_overflow | input | 1 | Execute produced an arithmetic overflow |
| m_data_fault | input | 1 | Memory stage data address fault |
| irq_req | input | 1 | External interrupt request |
| kill_f | output | 1 | Squash the fetch stage |
| kill_d | output | 1 | Squash the decode stage |
| kill_e | output | 1 | Squash the execute stage |
| handler_sel | output | 1 | Fetch takes the handler PC next |
| m_mem_ok | output | 1 | Memory-stage instruction may access memory |
| wb_suppress | output | 1 | Block writeback of the instruction now in writeback |
| cause_q | output | 3 | Recorded cause code |
| epc_q | output | PC_W | Recorded excepting PC |

## Verification
Several events can meet in one cycle. A pending interrupt can land on the same memory-stage instruction that also carries its own fault. An older instruction can commit while a younger one that is already being killed has a fault raised against it. The bench provokes both by issuing instructions back to back, with the interrupt request and the fault inputs timed to reach the same cycle. It judges the outcome by the one cause and PC that come out, taken from the scoreboard queue, and by the absence of any second commit.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;

    parameter int unsigned PC_W          = 32;
    localparam int unsigned NUM_PIPE_REGS = 3;   // decode, execute, memory records
    localparam int unsigned CAUSE_W       = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_IRQ        = 3'd1,
        CAUSE_FETCH_ADDR = 3'd2,
        CAUSE_ILLEGAL    = 3'd3,
        CAUSE_OVERFLOW   = 3'd4,
        CAUSE_DATA_ADDR  = 3'd5
    } cause_e;

    // one instruction's exception record as it moves down the pipe
    typedef struct packed {
        logic            valid;
        logic            flagged;
        cause_e          cause;
        logic [PC_W-1:0] pc;
    } slot_t;

    typedef struct packed {
        logic            irq_pend;
        logic            wb_sup;
        cause_e          cause;
        logic [PC_W-1:0] epc;
    } ctl_state_t;

    // cause attached when leaving register stage idx
    function automatic cause_e stage_cause(input int unsigned idx);
        case (idx)
            0:       return CAUSE_FETCH_ADDR;
            1:       return CAUSE_ILLEGAL;
            default: return CAUSE_OVERFLOW;
        endcase
    endfunction

endpackage

// File: rtl/exc_slot_stage.sv
module exc_slot_stage
    import exc_commit_pkg::*;
#(
    parameter cause_e DET_CAUSE = CAUSE_FETCH_ADDR
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  slot_t up_i,
    input  logic  det_i,
    output slot_t slot_o
);

    slot_t merged;
    slot_t slot_d;
    slot_t slot_q;

    always_comb begin
        merged = up_i;
        // an earlier flag is never overwritten by a later stage
        if (up_i.valid && det_i && !up_i.flagged) begin
            merged.flagged = 1'b1;
            merged.cause   = DET_CAUSE;
        end
        slot_d = flush ? '0 : merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/exc_commit_ctl.sv
module exc_commit_ctl
    import exc_commit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  slot_t           m_slot_i,
    input  logic            m_fault_i,
    input  logic            irq_i,
    output logic            commit_o,
    output logic            mem_ok_o,
    output logic            wb_suppress_o,
    output cause_e          cause_o,
    output logic [PC_W-1:0] epc_o
);

    ctl_state_t st_d;
    ctl_state_t st_q;
    logic       m_flag;
    logic       take_irq;
    logic       commit;
    cause_e     sel_cause;

    always_comb begin
        m_flag   = m_slot_i.valid && (m_slot_i.flagged || m_fault_i);
        take_irq = m_slot_i.valid && st_q.irq_pend;
        commit   = m_flag || take_irq;

        if (take_irq) begin
            sel_cause = CAUSE_IRQ;
        end else if (m_slot_i.flagged) begin
            sel_cause = m_slot_i.cause;
        end else begin
            sel_cause = CAUSE_DATA_ADDR;
        end

        st_d          = st_q;
        st_d.irq_pend = irq_i || (st_q.irq_pend && !take_irq);
        st_d.wb_sup   = commit;
        if (commit) begin
            st_d.cause = sel_cause;
            st_d.epc   = m_slot_i.pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o      = commit;
    assign mem_ok_o      = m_slot_i.valid && !commit;
    assign wb_suppress_o = st_q.wb_sup;
    assign cause_o       = st_q.cause;
    assign epc_o         = st_q.epc;

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
    import exc_commit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               f_valid,
    input  logic [PC_W-1:0]    f_pc,
    input  logic               f_addr_fault,
    input  logic               d_illegal,
    input  logic               e_overflow,
    input  logic               m_data_fault,
    input  logic               irq_req,
    output logic               kill_f,
    output logic               kill_d,
    output logic               kill_e,
    output logic               handler_sel,
    output logic               m_mem_ok,
    output logic               wb_suppress,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [PC_W-1:0]    epc_q
);

    slot_t                    chain [NUM_PIPE_REGS+1];
    logic [NUM_PIPE_REGS-1:0] det;
    logic                     commit;
    cause_e                   cause_rec;

    always_comb begin
        chain[0]         = '0;
        chain[0].valid   = f_valid;
        chain[0].pc      = f_pc;
        det              = {e_overflow, d_illegal, f_addr_fault};
    end

    for (genvar g = 0; g < NUM_PIPE_REGS; g++) begin : g_stage
        exc_slot_stage #(
            .DET_CAUSE (stage_cause(g))
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (commit),
            .up_i   (chain[g]),
            .det_i  (det[g]),
            .slot_o (chain[g+1])
        );
    end

    exc_commit_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_slot_i      (chain[NUM_PIPE_REGS]),
        .m_fault_i     (m_data_fault),
        .irq_i         (irq_req),
        .commit_o      (commit),
        .mem_ok_o      (m_mem_ok),
        .wb_suppress_o (wb_suppress),
        .cause_o       (cause_rec),
        .epc_o         (epc_q)
    );

    assign kill_f      = commit;
    assign kill_d      = commit;
    assign kill_e      = commit;
    assign handler_sel = commit;
    assign cause_q     = cause_rec;

endmodule

// File: rtl/exc_commit_checks.sv
module exc_commit_checks
    import exc_commit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               handler_sel,
    input logic               wb_suppress,
    input logic               m_mem_ok,
    input logic [CAUSE_W-1:0] cause_q,
    input logic [PC_W-1:0]    epc_q
);

    assert_wb_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        handler_sel |=> wb_suppress);

    assert_wb_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !handler_sel |=> !wb_suppress);

    assert_record_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !handler_sel |=> ($stable(cause_q) && $stable(epc_q)));

    assert_cause_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_suppress |-> (cause_q >= 3'd1 && cause_q <= 3'd5));

    assert_no_mem_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_sel |-> !m_mem_ok);

    assert_bubble_after_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        handler_sel |=> (!handler_sel && !m_mem_ok));

endmodule

bind exc_commit_unit exc_commit_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .handler_sel (handler_sel),
    .wb_suppress (wb_suppress),
    .m_mem_ok    (m_mem_ok),
    .cause_q     (cause_q),
    .epc_q       (epc_q)
);

// File: tb/sim_exc_commit_unit.sv
`timescale 1ns/1ps
module sim_exc_commit_unit;
    import exc_commit_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               f_valid, f_addr_fault, d_illegal, e_overflow, m_data_fault, irq_req;
    logic [PC_W-1:0]    f_pc;
    logic               kill_f, kill_d, kill_e, handler_sel, m_mem_ok, wb_suppress;
    logic [CAUSE_W-1:0] cause_q;
    logic [PC_W-1:0]    epc_q;

    typedef struct {
        logic [CAUSE_W-1:0] cause;
        logic [PC_W-1:0]    epc;
    } exp_t;

    exp_t exp_q [$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_en   = 1'b0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    exc_commit_unit u0 (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
        .f_addr_fault(f_addr_fault), .d_illegal(d_illegal), .e_overflow(e_overflow),
        .m_data_fault(m_data_fault), .irq_req(irq_req), .kill_f(kill_f), .kill_d(kill_d),
        .kill_e(kill_e), .handler_sel(handler_sel), .m_mem_ok(m_mem_ok),
        .wb_suppress(wb_suppress), .cause_q(cause_q), .epc_q(epc_q)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // scoreboard monitor: each writeback-suppress cycle consumes one expected commit
    always @(negedge clk) begin
        if (mon_en && wb_suppress) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected commit cause", 64'(cause_q), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cause_q == e.cause, "R4", "cause code", 64'(cause_q), 64'(e.cause));
                chk(epc_q == e.epc, "R3", "excepting pc", 64'(epc_q), 64'(e.epc));
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            f_valid = 0; f_addr_fault = 0; d_illegal = 0;
            e_overflow = 0; m_data_fault = 0; irq_req = 0;
        end
    endtask

    // flt[i]: bit0 fetch fault, bit1 illegal, bit2 overflow, bit3 data fault
    task automatic run_stream(input int n, input logic [PC_W-1:0] base,
                              input logic [7:0][3:0] flt, input int irq_c,
                              input bit pend_in, input string req);
        int j = -1;
        logic [CAUSE_W-1:0] ec = '0;
        for (int i = 0; i < n; i++) begin
            bit irq_now;
            irq_now = pend_in || (irq_c >= 0 && i + 3 > irq_c);
            if (irq_now || flt[i] != 4'd0) begin
                j = i;
                if (irq_now)          ec = 3'd1;
                else if (flt[i][0])   ec = 3'd2;
                else if (flt[i][1])   ec = 3'd3;
                else if (flt[i][2])   ec = 3'd4;
                else                  ec = 3'd5;
                break;
            end
        end
        if (j >= 0) exp_q.push_back('{cause: ec, epc: base + PC_W'(4 * j)});
        for (int c = 0; c <= ((j >= 0) ? j + 4 : n + 3); c++) begin
            bit exp_commit, mv;
            @(negedge clk);
            f_valid      = (c < n) && (j < 0 || c <= j + 3);
            f_pc         = base + PC_W'(4 * c);
            f_addr_fault = (c < n) ? flt[c][0] : 1'b0;
            d_illegal    = (c >= 1 && c - 1 < n) ? flt[c-1][1] : 1'b0;
            e_overflow   = (c >= 2 && c - 2 < n) ? flt[c-2][2] : 1'b0;
            m_data_fault = (c >= 3 && c - 3 < n) ? flt[c-3][3] : 1'b0;
            irq_req      = (c == irq_c);
            #5;
            exp_commit = (j >= 0 && c == j + 3);
            mv         = (c >= 3 && c - 3 < n && (j < 0 || c - 3 <= j));
            chk(handler_sel == exp_commit, req, "handler_sel (R1)", 64'(handler_sel), 64'(exp_commit));
            chk((kill_f && kill_d && kill_e) == exp_commit, "R5", "stage kills",
                64'({kill_f, kill_d, kill_e}), exp_commit ? 64'h7 : 64'h0);
            chk(m_mem_ok == (mv && !exp_commit), "R7", "m_mem_ok", 64'(m_mem_ok), 64'(mv && !exp_commit));
        end
        idle(3);
    endtask

    initial begin
        rst_n = 0; f_valid = 0; f_pc = '0; f_addr_fault = 0; d_illegal = 0;
        e_overflow = 0; m_data_fault = 0; irq_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1;
        mon_en = 1;
        #5;
        // R10 reset state
        chk(cause_q == '0, "R10", "cause after reset", 64'(cause_q), 64'd0);
        chk(epc_q == '0, "R10", "epc after reset", 64'(epc_q), 64'd0);
        chk(!wb_suppress && !handler_sel, "R10", "idle outputs after reset",
            64'({wb_suppress, handler_sel}), 64'd0);

        // R7 clean stream: no commit, memory access allowed
        run_stream(4, 32'h0000_1000, '0, -1, 0, "R7");
        // R4 each single cause, R1 timing
        run_stream(1, 32'h0000_2000, {28'd0, 4'b0001}, -1, 0, "R1");
        run_stream(1, 32'h0000_2100, {28'd0, 4'b0010}, -1, 0, "R4");
        run_stream(1, 32'h0000_2200, {28'd0, 4'b0100}, -1, 0, "R4");
        run_stream(1, 32'h0000_2300, {28'd0, 4'b1000}, -1, 0, "R4");
        // R2 priority among stages of one instruction
        run_stream(1, 32'h0000_3000, {28'd0, 4'b1111}, -1, 0, "R2");
        run_stream(1, 32'h0000_3100, {28'd0, 4'b1110}, -1, 0, "R2");
        run_stream(1, 32'h0000_3200, {28'd0, 4'b1100}, -1, 0, "R2");
        // R5 older commits, flagged younger instructions are squashed
        run_stream(4, 32'h0000_4000, {16'd0, 4'b0100, 4'b0010, 4'b0001, 4'b1000}, -1, 0, "R5");
        run_stream(4, 32'h0000_4100, {16'd0, 4'b0001, 4'b0001, 4'b0100, 4'b0000}, -1, 0, "R5");
        // R3 interrupt meets an overflowing instruction at commit
        run_stream(2, 32'h0000_5000, {24'd0, 4'b0000, 4'b0100}, 1, 0, "R3");

        // R8 interrupt with an empty pipe stays pending
        @(negedge clk); irq_req = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); irq_req = 0;
            #5;
            chk(!handler_sel, "R8", "no commit while memory stage empty", 64'(handler_sel), 64'd0);
        end
        run_stream(2, 32'h0000_6000, '0, -1, 1, "R8");

        // R9 fault inputs on empty stages are ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            f_valid = 0; f_addr_fault = 1; d_illegal = 1; e_overflow = 1; m_data_fault = 1;
            #5;
            chk(!handler_sel, "R9", "faults on empty slots", 64'(handler_sel), 64'd0);
        end
        idle(1);
        run_stream(2, 32'h0000_7000, '0, -1, 0, "R9");

        chk(exp_q.size() == 0, "R6", "expected commits never seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule